// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

This block produces a single HIGH pulse on `q` of a programmed length in clock cycles. It is the clocked counterpart of a monostable timer, and a down-counter replaces the usual resistor and capacitor. Two asynchronous trigger lines can start the pulse. `trig_rise` fires on its rising edge, but only while `trig_fall` is HIGH. `trig_fall` fires on its falling edge, but only while `trig_rise` is LOW. `q_n` always carries the inverse of `q`.

A trigger that arrives during a pulse normally restarts the count, so a steady train of triggers can hold `q` HIGH indefinitely. That makes any duty cycle from 0% to 100% reachable. With `lock_mode` set, such triggers are ignored and every pulse has the programmed length. The active-low `clear_n` ends a pulse at once and holds the block idle while it is LOW. The trigger lines and `clear_n` pass through a synchroniser with a fixed latency of `SYNC_STAGES` flops. `width_cyc` and `lock_mode` are treated as quasi-static configuration.

Top module: `retrig_oneshot`

## Requirements
- R1: A rising edge on `trig_rise` starts or restarts a pulse only if `trig_fall` is HIGH in the same cycle. An edge seen while `trig_fall` is LOW has no effect on `q`.
- R2: A falling edge on `trig_fall` starts or restarts a pulse only if `trig_rise` is LOW in the same cycle. An edge seen while `trig_rise` is HIGH has no effect on `q`.
- R3: With the default `SYNC_STAGES` = 2, an accepted trigger driven before clock edge E raises `q` right after edge E+2, a latency of three cycles. `q` then stays HIGH for exactly `width_cyc` cycles.
- R4: A `width_cyc` of 0 gives a pulse of one cycle.
- R5: With `lock_mode` LOW, an accepted trigger during a pulse reloads the count from zero and `q` stays HIGH without a gap. The pulse ends `width_cyc` cycles after the last trigger reaches the counter.
- R6: With `lock_mode` HIGH, triggers during a pulse are ignored. The pulse ends exactly `width_cyc` cycles after the trigger that started it, and a trigger after the pulse starts a new one.
- R7: `clear_n` LOW ends an active pulse three cycles after it is driven, with `q` LOW and `q_n` HIGH.
- R8: While `clear_n` is LOW, no trigger starts a pulse, and no pulse appears after `clear_n` is released.
- R9: If `clear_n` falls in the same cycle as a valid trigger edge, no pulse starts.
- R10: If `clear_n` rises in the same cycle as a valid trigger edge, that trigger starts a pulse.
- R11: `q_n` is the complement of `q` in every cycle. After reset, `q` is LOW and `q_n` is HIGH.
- R12: `width_cyc` is captured only when a trigger is accepted. A change during a pulse does not alter that pulse, and the next trigger uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active LOW |
| trig_rise | input | 1 | Asynchronous trigger, fires on its rising edge while `trig_fall` is HIGH |
| trig_fall | input | 1 | Asynchronous trigger, fires on its falling edge while `trig_rise` is LOW |
| clear_n | input | 1 | Asynchronous direct clear, active LOW |
| lock_mode | input | 1 | 1 = triggers during a pulse are ignored, 0 = they restart the count |
| width_cyc | input | W_BITS | Pulse length in clock cycles, 0 treated as 1 |
| q | output | 1 | Pulse output, HIGH while the pulse is active |
| q_n | output | 1 | Complement of `q` |

## Verification
The bench builds the block with `W_BITS` = 6 and the default two-stage synchroniser. The 6-bit width lets a single run cover the smallest pulse (width 0, one cycle) and the largest (63 cycles). It also keeps every retrigger train and lock-out window within a short, fully logged sample window. With two stages, the three-cycle latency is a fixed point in each expected waveform, so the clear and trigger coincidence cases resolve to exact cycles.

// File: rtl/oneshot_pkg.sv
// Shared types for the retriggerable one-shot.
// Assumes: one clock domain after the synchroniser; all lines sampled as a bundle.
package oneshot_pkg;

    // Asynchronous control lines, carried as one bundle through the synchroniser.
    typedef struct packed {
        logic clr_n;   // direct clear, active LOW
        logic dn;      // falling-edge trigger line
        logic up;      // rising-edge trigger line
    } os_lines_t;

    localparam int unsigned OS_LINE_BITS = $bits(os_lines_t);

endpackage

// File: rtl/os_sync.sv
// Multi-bit flop-chain synchroniser.
// What: delays each bit of d through STAGES flops.
// Assumes: the bits are independent; no bit relies on arriving with another.
module os_sync #(
    parameter int unsigned     WIDTH   = 3,
    parameter int unsigned     STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= RST_VAL;
            end
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/os_trig_detect.sv
// Edge detector with cross-gating for the two trigger lines.
// What: raises fire for one cycle on a rising edge of up while dn is HIGH,
//       or on a falling edge of dn while up is LOW, and never while clear is active.
// Assumes: up_s, dn_s and clr_s are already synchronised.
module os_trig_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic up_s,
    input  logic dn_s,
    input  logic clr_s,
    output logic fire
);

    logic up_d;
    logic dn_d;
    logic up_edge;
    logic dn_edge;

    // Hold the previous synchronised levels; the reset values can give no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_d <= 1'b0;
            dn_d <= 1'b0;
        end else begin
            up_d <= up_s;
            dn_d <= dn_s;
        end
    end

    // Qualify each edge by the level of the opposite line and by the clear.
    always_comb begin
        up_edge = up_s & ~up_d & dn_s;
        dn_edge = dn_d & ~dn_s & ~up_s;
        fire    = clr_s & (up_edge | dn_edge);
    end

    AST_FIRE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ($rose(up_s) || $fell(dn_s)));                       // R1
    AST_UP_GATED_BY_DN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(up_s) && !dn_s && !$fell(dn_s)) |-> !fire);             // R1
    AST_DN_GATED_BY_UP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dn_s) && up_s && !$rose(up_s)) |-> !fire);              // R2

endmodule

// File: rtl/os_timer.sv
// Pulse timer with retrigger and lock-out.
// What: drives q HIGH for width_in cycles (0 counts as 1) from an accepted fire.
//       Without lock-out, a fire during a pulse reloads the count.
//       A LOW clr_ok clears the timer in the next cycle.
// Assumes: width_in and lockout are stable around an accepted fire.
module os_timer #(
    parameter int unsigned W_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              clr_ok,
    input  logic              lockout,
    input  logic [W_BITS-1:0] width_in,
    output logic              q,
    output logic              q_n
);

    localparam logic [W_BITS-1:0] ONE = W_BITS'(1);

    logic [W_BITS-1:0] remain;
    logic [W_BITS-1:0] load_val;
    logic              accept;
    logic              last_cyc;

    // Work out the reload value, whether this fire is accepted, and the final cycle.
    always_comb begin
        load_val = (width_in == '0) ? '0 : (width_in - ONE);
        accept   = fire & (~q | ~lockout);
        last_cyc = q & (remain == '0);
    end

    // Run the count and drive the pulse output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= 1'b0;
            remain <= '0;
        end else if (!clr_ok) begin
            q      <= 1'b0;
            remain <= '0;
        end else if (accept) begin
            q      <= 1'b1;
            remain <= load_val;
        end else if (q) begin
            if (remain == '0) begin
                q <= 1'b0;
            end else begin
                remain <= remain - ONE;
            end
        end
    end

    // Drive the complementary output from its own flop, set up to match q.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_n <= 1'b1;
        end else if (!clr_ok) begin
            q_n <= 1'b1;
        end else if (accept) begin
            q_n <= 1'b0;
        end else if (last_cyc) begin
            q_n <= 1'b1;
        end
    end

    AST_QN_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        q_n == !q);                                                    // R11
    AST_CLEAR_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_ok |=> (!q && q_n));                                      // R7
    AST_START_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (!q && fire && clr_ok) |=> q);                                 // R3
    AST_RETRIG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (q && fire && clr_ok && !lockout) |=> (q && remain == $past(load_val))); // R5
    AST_LOCKOUT_COUNTS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (q && lockout && clr_ok && remain != '0) |=> (q && remain == $past(remain) - ONE)); // R6
    AST_ZERO_WIDTH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && clr_ok && width_in == '0) |=> (q && remain == '0)); // R4

endmodule

// File: rtl/retrig_oneshot.sv
// Retriggerable resettable one-shot, top level.
// What: synchronises the trigger and clear lines, detects the cross-gated
//       trigger edges and times the output pulse in clock cycles.
// Assumes: width_cyc and lock_mode are quasi-static configuration. The
//       trigger-to-q latency is SYNC_STAGES + 1 cycles.
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int unsigned W_BITS      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_rise,
    input  logic              trig_fall,
    input  logic              clear_n,
    input  logic              lock_mode,
    input  logic [W_BITS-1:0] width_cyc,
    output logic              q,
    output logic              q_n
);

    os_lines_t raw_lines;
    os_lines_t sync_lines;
    logic      fire;

    // Bundle the asynchronous lines for the synchroniser.
    always_comb begin
        raw_lines.up    = trig_rise;
        raw_lines.dn    = trig_fall;
        raw_lines.clr_n = clear_n;
    end

    os_sync #(
        .WIDTH   (OS_LINE_BITS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_lines),
        .q     (sync_lines)
    );

    os_trig_detect u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .up_s  (sync_lines.up),
        .dn_s  (sync_lines.dn),
        .clr_s (sync_lines.clr_n),
        .fire  (fire)
    );

    os_timer #(
        .W_BITS (W_BITS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .clr_ok   (sync_lines.clr_n),
        .lockout  (lock_mode),
        .width_in (width_cyc),
        .q        (q),
        .q_n      (q_n)
    );

    AST_NO_START_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_lines.clr_n && !q) |=> !q);                             // R8

endmodule

// File: tb/retrig_oneshot_bench.sv
// Directed bench for retrig_oneshot. Each scenario fills a per-cycle input
// script, replays it and logs q and q_n at falling clock edges. Inputs are
// driven at falling edges too, so an input set at log index i shows on q at i+3.
module retrig_oneshot_bench;

    localparam int unsigned WB  = 6;
    localparam int          LEN = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_rise = 1'b0;
    logic          trig_fall = 1'b1;
    logic          clear_n = 1'b1;
    logic          lock_mode = 1'b0;
    logic [WB-1:0] width_cyc = '0;
    logic          q;
    logic          q_n;

    int checks = 0;
    int failures = 0;

    logic          s_up [LEN];
    logic          s_dn [LEN];
    logic          s_clr[LEN];
    logic          s_lk [LEN];
    logic [WB-1:0] s_w  [LEN];
    logic          l_q  [LEN];
    logic          l_qn [LEN];

    always #2.5 clk = ~clk;

    retrig_oneshot #(.W_BITS(WB), .SYNC_STAGES(2)) u_retrig_oneshot (
        .clk(clk), .rst_n(rst_n), .trig_rise(trig_rise), .trig_fall(trig_fall),
        .clear_n(clear_n), .lock_mode(lock_mode), .width_cyc(width_cyc),
        .q(q), .q_n(q_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Fill the script with idle inputs, the given width and the given mode.
    task automatic script_idle(input int w, input bit lk);
        for (int i = 0; i < LEN; i++) begin
            s_up[i] = 1'b0; s_dn[i] = 1'b1; s_clr[i] = 1'b1;
            s_lk[i] = lk;   s_w[i]  = WB'(w);
        end
    endtask

    task automatic set_up(input int lo, input int hi);
        for (int i = lo; i <= hi; i++) s_up[i] = 1'b1;
    endtask

    // Replay n cycles: log the outputs, then drive the next inputs; idle afterwards.
    task automatic replay(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            l_q[i] = q; l_qn[i] = q_n;
            trig_rise = s_up[i]; trig_fall = s_dn[i]; clear_n = s_clr[i];
            lock_mode = s_lk[i]; width_cyc = s_w[i];
        end
        trig_rise = 1'b0; trig_fall = 1'b1; clear_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    function automatic int count_q(input int lo, input int hi, input logic v);
        int c = 0;
        for (int i = lo; i <= hi; i++) if (l_q[i] == v) c++;
        return c;
    endfunction

    // q must equal v over [lo,hi]; the count of matching samples is reported.
    task automatic expect_span(input int lo, input int hi, input logic v, input string req);
        int c = count_q(lo, hi, v);
        chk(c == hi - lo + 1, req, c, hi - lo + 1);
    endtask

    task automatic expect_qn(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) if (l_qn[i] !== ~l_q[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset();
        chk(q == 1'b0, "R11 reset q", int'(q), 0);
        chk(q_n == 1'b1, "R11 reset q_n", int'(q_n), 1);
    endtask

    task automatic t_rise_trigger();   // R1 R3
        script_idle(5, 1'b0); set_up(1, 2); replay(14);
        expect_span(0, 3, 1'b0, "R3 latency, quiet before");
        expect_span(4, 8, 1'b1, "R1 R3 width 5 pulse");
        expect_span(9, 13, 1'b0, "R3 pulse end");
        expect_qn(14, "R11 complement");
    endtask

    task automatic t_gating();   // R1 R2
        script_idle(3, 1'b0);
        for (int i = 1; i < 33; i++) s_dn[i] = 1'b0;
        for (int i = 20; i < 25; i++) s_dn[i] = 1'b1;
        set_up(10, 29);
        replay(40);
        expect_span(4, 6, 1'b1, "R2 falling trigger pulse");
        expect_span(7, 24, 1'b0, "R1 rise blocked by low trig_fall");
        expect_span(25, 39, 1'b0, "R2 fall blocked by high trig_rise");
        expect_qn(40, "R11 complement");
    endtask

    task automatic t_widths();   // R4
        script_idle(0, 1'b0); set_up(1, 2); replay(10);
        chk(count_q(0, 9, 1'b1) == 1 && l_q[4] == 1'b1, "R4 width 0",
            count_q(0, 9, 1'b1), 1);
        script_idle(63, 1'b0); set_up(1, 2); replay(72);
        expect_span(4, 66, 1'b1, "R4 width 63 body");
        expect_span(67, 71, 1'b0, "R4 width 63 end");
    endtask

    task automatic t_retrigger();   // R5
        script_idle(8, 1'b0);
        for (int k = 0; k < 6; k++) set_up(1 + 5 * k, 2 + 5 * k);
        replay(45);
        expect_span(4, 36, 1'b1, "R5 continuous retrigger");
        expect_span(37, 44, 1'b0, "R5 end after last trigger");
    endtask

    task automatic t_lockout();   // R6
        script_idle(8, 1'b1); set_up(1, 2); set_up(6, 7); set_up(20, 21);
        replay(35);
        expect_span(4, 11, 1'b1, "R6 locked pulse");
        expect_span(12, 22, 1'b0, "R6 retrigger ignored");
        expect_span(23, 30, 1'b1, "R6 new pulse after end");
        lock_mode = 1'b0;
    endtask

    task automatic t_clear_cut();   // R7
        script_idle(20, 1'b0); set_up(1, 2);
        for (int i = 8; i <= 12; i++) s_clr[i] = 1'b0;
        replay(30);
        expect_span(4, 10, 1'b1, "R7 pulse before clear");
        expect_span(11, 29, 1'b0, "R7 cleared");
        chk(l_qn[11] == 1'b1, "R7 q_n high", int'(l_qn[11]), 1);
    endtask

    task automatic t_clear_hold();   // R8
        script_idle(4, 1'b0);
        for (int i = 1; i <= 15; i++) s_clr[i] = 1'b0;
        set_up(4, 5); s_dn[8] = 1'b0; s_dn[9] = 1'b0;
        replay(30);
        expect_span(0, 29, 1'b0, "R8 no pulse under clear");
    endtask

    task automatic t_clear_coincide();   // R9 R10
        script_idle(4, 1'b0);
        for (int i = 1; i <= 6; i++) s_clr[i] = 1'b0;
        set_up(1, 2); replay(25);
        expect_span(0, 24, 1'b0, "R9 clear falls with trigger");
        script_idle(4, 1'b0);
        for (int i = 1; i <= 4; i++) s_clr[i] = 1'b0;
        set_up(5, 6); replay(20);
        expect_span(8, 11, 1'b1, "R10 release with trigger");
        expect_span(12, 19, 1'b0, "R10 pulse end");
    endtask

    task automatic t_width_capture();   // R12
        script_idle(6, 1'b0);
        for (int i = 5; i < LEN; i++) s_w[i] = WB'(30);
        set_up(1, 2); set_up(20, 21);
        replay(60);
        expect_span(4, 9, 1'b1, "R12 width held at start");
        expect_span(10, 22, 1'b0, "R12 no stretch from width change");
        expect_span(23, 52, 1'b1, "R12 new width on next trigger");
        expect_qn(60, "R11 complement");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        t_reset();
        t_rise_trigger();
        t_gating();
        t_widths();
        t_retrigger();
        t_lockout();
        t_clear_cut();
        t_clear_hold();
        t_clear_coincide();
        t_width_capture();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule